// File: doc/BRIEF.md
# Multi-Bank SDRAM Command Tracker

This block watches the command pins of a synchronous DRAM interface. On every rising clock edge it turns the four active-low strobes (chip select, row strobe, column strobe, write enable) into one command. For each bank it keeps a record of whether the bank is idle or holds an open row, and which row that is. Because each bank has its own state, one bank can be opened while another bank is in the middle of a read or write burst, and every command is judged against the state of the bank it addresses.

The outputs are registered. They carry the command decoded on the last edge, the bank field sampled on that edge, a one-cycle flag for a command that the current bank state does not allow, the captured column address, the open or idle status of every bank, and the open row of every bank. An optional per-bank timer enforces a minimum number of edges between an activate and the first read or write to that bank. It is sized by `ACT_GAP` and left out when `ACT_GAP` is 1 or less.

A bus monitor or a controller self-check would place this block on the command bus. It drives nothing back onto the bus, and an illegal command only raises the flag; the bank state is never corrupted by it.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With `cs_n` low, the pins {`ras_n`,`cas_n`,`we_n`} decode as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 110 burst stop, 000 mode-register load, 111 no-op. `cmd_o` encodes these as NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5, BST=6, MRS=7, and it shows the command sampled on the previous rising edge.
- R2: With `cs_n` high the command is NOP, whatever the other three pins are, and no bank state changes.
- R3: An activate to an idle bank opens that bank and stores `addr[12:0]` as its open row. Every other bank keeps its state and row.
- R4: An activate to a bank that already has an open row sets `illegal_o` for one cycle and leaves that bank open with its old row.
- R5: A read or write to an idle bank sets `illegal_o` for one cycle.
- R6: A read or write that comes fewer than `ACT_GAP` (default 3) edges after the activate of its bank sets `illegal_o`. At exactly `ACT_GAP` edges or more it is legal.
- R7: A precharge with `addr[10]` low closes only the bank selected by `ba`. With `addr[10]` high it closes every bank. A precharge is never illegal.
- R8: A refresh while any bank is open sets `illegal_o`. A refresh with all banks idle is legal. Neither changes any bank state.
- R9: `col_o` captures `addr[9:0]` on a legal read or write and holds its value on every other command. `cmd_bank_o` is `ba` as sampled on each edge.
- R10: Synchronous active-high `rst` clears every bank to idle with row 0, and sets `cmd_o` to NOP, `illegal_o` to 0, `col_o` to 0 and `cmd_bank_o` to 0.
- R11: Burst stop, mode-register load and no-op never set `illegal_o` and leave all bank state unchanged.
- R12: `open_rows_o[b*13 +: 13]` is the open row of bank b. `bank_open_o[b]` is 1 while bank b is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples the pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address field |
| addr | input | 13 | Row or column address; bit 10 selects all banks on precharge |
| cmd_o | output | 3 | Decoded command from the last edge |
| cmd_bank_o | output | 2 | Bank field sampled on the last edge |
| illegal_o | output | 1 | Last command was not allowed in its bank's state |
| col_o | output | 10 | Column of the last legal read or write |
| bank_open_o | output | 4 | Per-bank open flag |
| open_rows_o | output | 52 | Per-bank open row, 13 bits per bank |

## Verification
The assertions assume that `ba` and `addr` are driven to known values whenever `cs_n` is low, and that the strobes change only between clock edges. The bench meets this by driving every pin on the falling edge. It parks the strobes at a deselected, all-high state between commands and keeps `ba` within the four banks. The assertions also assume that the bench never drives an unknown on a strobe during reset release. To keep that true, the bench holds the pins at their no-op value from time zero.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_BST = 3'd6,
        CMD_MRS = 3'd7
    } cmd_e;

    // Address bit that widens a precharge to every bank
    localparam int unsigned ALL_BANK_BIT = 10;

    typedef struct packed {
        cmd_e cmd;
        logic all_banks;
        logic is_rw;
    } decoded_t;

    // Strobes are active low; a high chip select masks everything else
    function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                3'b001:  c = CMD_REF;
                3'b110:  c = CMD_BST;
                3'b000:  c = CMD_MRS;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic [ROW_W-1:0]     addr,
    output decoded_t             dec,
    output logic [NUM_BANKS-1:0] bank_sel
);

    cmd_e cmd_w;

    always_comb begin
        cmd_w         = decode_pins(cs_n, ras_n, cas_n, we_n);
        dec.cmd       = cmd_w;
        dec.all_banks = addr[ALL_BANK_BIT];
        dec.is_rw     = (cmd_w == CMD_RD) || (cmd_w == CMD_WR);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        assign bank_sel[b] = (ba == BA_W'(b));
    end

    always_comb begin
        if (cs_n) begin
            assert (cmd_w == CMD_NOP);  // R2
        end
    end

endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
    parameter int ROW_W   = 13,
    parameter int ACT_GAP = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_en,
    input  logic             pre_en,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             rw_ready
);

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open  <= 1'b0;
            open_row <= '0;
        end else if (act_en) begin
            is_open  <= 1'b1;
            open_row <= row_in;
        end else if (pre_en) begin
            is_open  <= 1'b0;
        end
    end

    if (ACT_GAP > 1) begin : g_gap
        localparam int CNT_W = $clog2(ACT_GAP);
        localparam logic [CNT_W-1:0] LOAD = CNT_W'(ACT_GAP - 1);
        logic [CNT_W-1:0] wait_cnt;

        always_ff @(posedge clk) begin
            if (rst) begin
                wait_cnt <= '0;
            end else if (act_en) begin
                wait_cnt <= LOAD;
            end else if (wait_cnt != '0) begin
                wait_cnt <= wait_cnt - 1'b1;
            end
        end
        assign rw_ready = (wait_cnt == '0);

        AST_GAP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
            act_en |=> !rw_ready);  // R6
    end else begin : g_nogap
        assign rw_ready = 1'b1;
    end

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        act_en |=> (is_open && open_row == $past(row_in)));  // R3
    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (pre_en && !act_en) |=> !is_open);  // R7
    AST_ROW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !act_en |=> $stable(open_row));  // R4

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int ACT_GAP   = 3,
    localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [BA_W-1:0]            ba,
    input  logic [ROW_W-1:0]           addr,
    output logic [2:0]                 cmd_o,
    output logic [BA_W-1:0]            cmd_bank_o,
    output logic                       illegal_o,
    output logic [COL_W-1:0]           col_o,
    output logic [NUM_BANKS-1:0]       bank_open_o,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows_o
);

    decoded_t             dec;
    logic [NUM_BANKS-1:0] bank_sel;
    logic [NUM_BANKS-1:0] is_open;
    logic [NUM_BANKS-1:0] rw_ready;
    logic [NUM_BANKS-1:0] act_en;
    logic [NUM_BANKS-1:0] pre_en;
    logic [ROW_W-1:0]     row_of [NUM_BANKS];
    logic                 sel_open;
    logic                 sel_ready;
    logic                 any_open;
    logic                 illegal_now;
    logic                 rw_ok;

    cmd_e             cmd_q;
    logic [BA_W-1:0]  bank_q;
    logic             illegal_q;
    logic [COL_W-1:0] col_q;

    sdram_cmd_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W)
    ) u_decode (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ba       (ba),
        .addr     (addr),
        .dec      (dec),
        .bank_sel (bank_sel)
    );

    always_comb begin
        sel_open  = is_open[ba];
        sel_ready = rw_ready[ba];
        any_open  = |is_open;
        case (dec.cmd)
            CMD_ACT: illegal_now = sel_open;
            CMD_RD,
            CMD_WR:  illegal_now = !sel_open || !sel_ready;
            CMD_REF: illegal_now = any_open;
            default: illegal_now = 1'b0;
        endcase
        rw_ok = dec.is_rw && !illegal_now;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign act_en[b] = (dec.cmd == CMD_ACT) && bank_sel[b] && !is_open[b];
        assign pre_en[b] = (dec.cmd == CMD_PRE) && (dec.all_banks || bank_sel[b]);

        sdram_bank_state #(
            .ROW_W   (ROW_W),
            .ACT_GAP (ACT_GAP)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .act_en   (act_en[b]),
            .pre_en   (pre_en[b]),
            .row_in   (addr),
            .is_open  (is_open[b]),
            .open_row (row_of[b]),
            .rw_ready (rw_ready[b])
        );

        assign open_rows_o[b*ROW_W +: ROW_W] = row_of[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= CMD_NOP;
            bank_q    <= '0;
            illegal_q <= 1'b0;
            col_q     <= '0;
        end else begin
            cmd_q     <= dec.cmd;
            bank_q    <= ba;
            illegal_q <= illegal_now;
            if (rw_ok) begin
                col_q <= addr[COL_W-1:0];
            end
        end
    end

    assign cmd_o       = cmd_q;
    assign cmd_bank_o  = bank_q;
    assign illegal_o   = illegal_q;
    assign col_o       = col_q;
    assign bank_open_o = is_open;

    AST_CSN_NOP: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cmd_o == 3'(CMD_NOP) && !illegal_o));  // R2
    AST_ACT_OPEN_FLAG: assert property (@(posedge clk) disable iff (rst)
        (dec.cmd == CMD_ACT && is_open[ba]) |=> illegal_o);  // R4
    AST_RW_IDLE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (dec.is_rw && !is_open[ba]) |=> illegal_o);  // R5
    AST_REF_OPEN_FLAG: assert property (@(posedge clk) disable iff (rst)
        (dec.cmd == CMD_REF && |is_open) |=> (illegal_o && $stable(bank_open_o)));  // R8
    AST_COL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !dec.is_rw |=> $stable(col_o));  // R9
    AST_QUIET_CMDS: assert property (@(posedge clk) disable iff (rst)
        (dec.cmd == CMD_BST || dec.cmd == CMD_MRS || dec.cmd == CMD_NOP)
        |=> (!illegal_o && $stable(bank_open_o) && $stable(open_rows_o)));  // R11

endmodule

// File: tb/sdram_cmd_tracker_bench.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_bench;

    localparam int NB  = 4;
    localparam int RW  = 13;
    localparam int CW  = 10;
    localparam int GAP = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [RW-1:0] addr = '0;
    logic [2:0] cmd_o;
    logic [1:0] cmd_bank_o;
    logic illegal_o;
    logic [CW-1:0] col_o;
    logic [NB-1:0] bank_open_o;
    logic [NB*RW-1:0] open_rows_o;

    int errors = 0;
    int checks = 0;
    int edge_no = 0;
    logic [NB-1:0] m_open = '0;
    logic [RW-1:0] m_row [NB];
    int m_act [NB];
    logic [CW-1:0] m_col = '0;

    always #2 clk = ~clk;

    sdram_cmd_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .ACT_GAP(GAP)) u_sdram_cmd_tracker (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o),
        .illegal_o(illegal_o), .col_o(col_o), .bank_open_o(bank_open_o),
        .open_rows_o(open_rows_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Table from R1/R2: pins = {cs_n, ras_n, cas_n, we_n}
    function automatic logic [2:0] exp_cmd(input logic [3:0] p);
        if (p[3]) return 3'd0;
        case (p[2:0])
            3'b011: return 3'd1;
            3'b101: return 3'd2;
            3'b100: return 3'd3;
            3'b010: return 3'd4;
            3'b001: return 3'd5;
            3'b110: return 3'd6;
            3'b000: return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [NB*RW-1:0] packed_rows();
        logic [NB*RW-1:0] v;
        for (int b = 0; b < NB; b++) v[b*RW +: RW] = m_row[b];
        return v;
    endfunction

    // One command per edge: drive at a falling edge, check at the next one
    task automatic issue(input logic [3:0] p, input logic [1:0] b,
                         input logic [RW-1:0] a, input string tag);
        logic [2:0] c;
        logic ill;
        c = exp_cmd(p);
        {cs_n, ras_n, cas_n, we_n} = p;
        ba = b;
        addr = a;
        edge_no++;
        ill = 1'b0;
        case (c)
            3'd1: if (m_open[b]) ill = 1'b1;
                  else begin m_open[b] = 1'b1; m_row[b] = a; m_act[b] = edge_no; end
            3'd2, 3'd3: if (!m_open[b] || (edge_no - m_act[b]) < GAP) ill = 1'b1;
                        else m_col = a[CW-1:0];
            3'd4: if (a[10]) m_open = '0; else m_open[b] = 1'b0;
            3'd5: ill = |m_open;
            default: ;
        endcase
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        chk(tag, "cmd_o R1", 64'(cmd_o), 64'(c));
        chk(tag, "cmd_bank_o R9", 64'(cmd_bank_o), 64'(b));
        chk(tag, "illegal_o", 64'(illegal_o), 64'(ill));
        chk(tag, "bank_open_o R12", 64'(bank_open_o), 64'(m_open));
        chk(tag, "open_rows_o R12", 64'(open_rows_o), 64'(packed_rows()));
        chk(tag, "col_o R9", 64'(col_o), 64'(m_col));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            edge_no++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R10", "cmd_o", 64'(cmd_o), 64'd0);
        chk("R10", "illegal_o", 64'(illegal_o), 64'd0);
        chk("R10", "bank_open_o", 64'(bank_open_o), 64'd0);
        chk("R10", "open_rows_o", 64'(open_rows_o), 64'd0);
        chk("R10", "col_o", 64'(col_o), 64'd0);
        chk("R10", "cmd_bank_o", 64'(cmd_bank_o), 64'd0);
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 16; i++) begin
            issue(4'(i), 2'd1, 13'h0155 + 13'(i), "R1");
        end
        issue(4'b0010, 2'd0, 13'h0400, "R7");
    endtask

    task automatic t_interleave();
        issue(4'b0011, 2'd0, 13'h1ABC, "R3");
        idle(2);
        issue(4'b0011, 2'd2, 13'h0777, "R3");
        issue(4'b0101, 2'd0, 13'h0123, "R6");
        issue(4'b0100, 2'd2, 13'h0321, "R6");
        idle(1);
        issue(4'b0100, 2'd2, 13'h03FF, "R6");
        issue(4'b0101, 2'd1, 13'h0011, "R5");
        issue(4'b0100, 2'd3, 13'h0022, "R5");
        issue(4'b0011, 2'd0, 13'h0001, "R4");
        issue(4'b0010, 2'd0, 13'h0000, "R7");
        issue(4'b0101, 2'd0, 13'h0044, "R5");
        issue(4'b0001, 2'd0, 13'h0000, "R8");
        issue(4'b0010, 2'd1, 13'h0400, "R7");
        issue(4'b0001, 2'd0, 13'h0000, "R8");
    endtask

    task automatic t_gap();
        issue(4'b0011, 2'd3, 13'h1FFF, "R3");
        issue(4'b0101, 2'd3, 13'h0005, "R6");
        issue(4'b0101, 2'd3, 13'h0006, "R6");
        issue(4'b0101, 2'd3, 13'h0007, "R6");
        issue(4'b0010, 2'd3, 13'h0000, "R7");
    endtask

    task automatic t_csn();
        issue(4'b1011, 2'd1, 13'h0AAA, "R2");
        issue(4'b1101, 2'd1, 13'h0AAA, "R2");
        issue(4'b1000, 2'd2, 13'h0AAA, "R2");
    endtask

    task automatic t_quiet();
        issue(4'b0011, 2'd1, 13'h0B0B, "R3");
        issue(4'b0011, 2'd2, 13'h0C0C, "R3");
        issue(4'b0110, 2'd1, 13'h0000, "R11");
        issue(4'b0000, 2'd2, 13'h0033, "R11");
        issue(4'b0111, 2'd0, 13'h0000, "R11");
        issue(4'b0010, 2'd1, 13'h0000, "R7");
        issue(4'b0010, 2'd2, 13'h0000, "R7");
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin m_row[b] = '0; m_act[b] = 0; end
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_sweep();
        t_interleave();
        t_gap();
        t_csn();
        t_quiet();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule